// File: doc/BRIEF.md
# Posit Divider (32-bit, two exponent bits)

This unit divides one 32-bit posit by another. The posit format has two exponent bits, so each regime step scales the value by 16. A caller puts the two operands on `dividend` and `divisor` and raises `start` for one cycle while the unit is idle. The unit then works on the division internally, one quotient bit per cycle. It pulses `done` when the encoded result is present on `quotient`, and it keeps that value until the next accepted start.

Inside, each operand is unpacked into sign, regime value k, exponent and fraction with the hidden bit. A negative operand is first two's-complement negated. The unit subtracts the regimes and the exponents, and a negative exponent difference borrows one regime step. The dividend fraction, scaled up by 2^30, goes through an iterative integer divider together with the divisor fraction. If the quotient lacks its leading bit, it is normalised by one place. The result is then re-encoded with round-to-nearest-even, where a non-zero division remainder counts as sticky information. A parameter selects a restoring or a non-restoring step for the iterative divider. Both give identical results.

Top module: `posit_divider`

## Requirements
- R1: If either operand is NaR (0x80000000), or the divisor is zero, the result is NaR (0x80000000).
- R2: A zero dividend with a divisor that is neither zero nor NaR gives 0x00000000.
- R3: The result sign is the XOR of the operand sign bits (bit 31). A negative operand is negated before division and a negative result is the two's complement of the magnitude. Examples: -3/2 = 0xBC000000 and 1/(-1) = 0xC0000000.
- R4: Quotients that are exactly representable come out exact. Examples: 3/2 = 0x44000000, 1/2 = 0x38000000, 8/4 = 0x48000000 and 16/0.5 = 0x64000000.
- R5: When the dividend fraction is below the divisor fraction, the quotient is shifted left once and the exponent is decremented. Exponent 0 wraps to 3 and the regime value drops by one. Example: 1/1.5 = 0x3AAAAAAB.
- R6: The result is rounded to nearest, with ties going to the even encoding. The sticky term includes a non-zero remainder. Examples: 1/3 = 0x32AAAAAB, 0x40000001/256 = 0x10000000 (tie, kept even) and 0x40000003/256 = 0x10000002 (tie, rounded up to even).
- R7: A result regime longer than 30 bits saturates to 0x7FFFFFFF for a non-negative regime value and to 0x00000001 for a negative one, before the sign is applied.
- R8: With a regime of 29 bits, exponent bit 0 is the round bit. With a regime of 30 bits, exponent bit 1 is the round bit and exponent bit 0 is sticky. Examples: maxpos/128 = 0x7FFFFFFC, maxpos/32 = 0x7FFFFFFE, maxpos/16 = 0x7FFFFFFE, maxpos/2 = 0x7FFFFFFF, 1/maxpos = 0x00000001.
- R9: An accepted start raises `busy` from the next cycle. `done` pulses for exactly one cycle, 32 clock edges after the accepting edge, whatever the operands are.
- R10: `start` has no effect while `busy` is high. `quotient` keeps its value at every cycle where `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; accepted only while idle |
| dividend | input | 32 | Posit numerator |
| divisor | input | 32 | Posit denominator |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| quotient | output | 32 | Posit result, held until the next accepted start |

## Verification
The operand pairs cover several cases. Exact ratios show that regime, exponent and fraction are subtracted correctly. Pairs whose dividend fraction is smaller than the divisor fraction exercise the normalising shift and the exponent wrap. Non-terminating ratios such as 1/3 show that the remainder feeds the sticky term. Exact half-way pairs built with a long regime separate round-up-to-even from keep-even. Pairs near the largest and smallest magnitudes exercise the 29-bit and 30-bit regime paths and full saturation, and mixed-sign pairs exercise negation on both sides. Special operands (NaR, zero) confirm the override paths. Extra start pulses while busy show that a running division is not disturbed.

// File: rtl/posit_div_pkg.sv
`timescale 1ns/1ps
package posit_div_pkg;
   typedef enum logic [1:0] {
      PD_IDLE = 2'd0,
      PD_RUN  = 2'd1,
      PD_FIN  = 2'd2
   } pd_state_e;

   typedef enum logic [1:0] {
      SP_NONE = 2'd0,
      SP_NAR  = 2'd1,
      SP_ZERO = 2'd2
   } pd_special_e;
endpackage

// File: rtl/posit_div_unpack.sv
`timescale 1ns/1ps
module posit_div_unpack #(
   parameter int NBITS = 32,
   parameter int ES    = 2,
   parameter int KW    = 8,
   parameter int FW    = NBITS - 1
) (
   input  logic [NBITS-1:0]     word,
   output logic                 sgn,
   output logic                 is_zero,
   output logic                 is_nar,
   output logic signed [KW-1:0] k,
   output logic [ES-1:0]        e,
   output logic [FW-1:0]        frac
);
   localparam int CW = $clog2(NBITS + 2);
   localparam logic signed [KW-1:0] K_ONE = KW'(1);
   localparam logic [NBITS-1:0] NAR_WORD = {1'b1, {(NBITS-1){1'b0}}};

   logic [NBITS-1:0] mag;
   logic [NBITS-1:0] rest;
   logic [CW-1:0]    run;
   logic signed [KW-1:0] run_s;
   logic             lead;
   logic             stop;

   always_comb begin
      sgn     = word[NBITS-1];
      is_zero = (word == '0);
      is_nar  = (word == NAR_WORD);
      mag     = sgn ? (~word + 1'b1) : word;
      lead    = mag[NBITS-2];
      run     = '0;
      stop    = 1'b0;
      for (int i = NBITS-2; i >= 0; i--) begin
         if (!stop && (mag[i] == lead)) run = run + 1'b1;
         else stop = 1'b1;
      end
      // drop sign, regime run and terminating bit
      rest  = mag << (run + 2);
      run_s = KW'(run);
      k     = lead ? (run_s - K_ONE) : (-run_s);
      e     = rest[NBITS-1 -: ES];
      frac  = {1'b1, rest[NBITS-ES-1 -: FW-1]};
   end
endmodule

// File: rtl/posit_div_frac.sv
`timescale 1ns/1ps
module posit_div_frac #(
   parameter int FW           = 31,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [FW-1:0] dvd,
   input  logic [FW-1:0] dvs,
   output logic [FW-1:0] quot,
   output logic          rem_nz
);
   localparam int RW = FW + 3;

   logic signed [RW-1:0] part, divr, base, part_nx;
   logic                 first, qbit;

   assign base = first ? part : (part <<< 1);

   generate
      if (NONRESTORING) begin : g_nonrestoring
         assign part_nx = part[RW-1] ? (base + divr) : (base - divr);
         assign qbit    = !part_nx[RW-1];
         assign rem_nz  = part[RW-1] ? ((part + divr) != '0) : (part != '0);
      end else begin : g_restoring
         logic signed [RW-1:0] diff;
         assign diff    = base - divr;
         assign qbit    = !diff[RW-1];
         assign part_nx = qbit ? diff : base;
         assign rem_nz  = (part != '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         part  <= '0;
         divr  <= '0;
         quot  <= '0;
         first <= 1'b0;
      end else if (load) begin
         part  <= {{(RW-FW){1'b0}}, dvd};
         divr  <= {{(RW-FW){1'b0}}, dvs};
         quot  <= '0;
         first <= 1'b1;
      end else if (step) begin
         part  <= part_nx;
         quot  <= {quot[FW-2:0], qbit};
         first <= 1'b0;
      end
   end
endmodule

// File: rtl/posit_div_pack.sv
`timescale 1ns/1ps
module posit_div_pack #(
   parameter int NBITS = 32,
   parameter int ES    = 2,
   parameter int KW    = 8,
   parameter int FW    = NBITS - 1
) (
   input  logic                 sgn,
   input  logic signed [KW-1:0] k,
   input  logic [ES-1:0]        e,
   input  logic [FW-1:0]        q,
   input  logic                 rem_nz,
   output logic [NBITS-1:0]     res
);
   localparam int RL_MAX  = NBITS - 2;
   localparam int RL_EDGE = NBITS - 3;
   localparam int RL_FULL = NBITS - 4;
   localparam logic signed [KW-1:0] K_ONE = KW'(1);
   localparam logic [NBITS-1:0] MAXP   = {1'b0, {(NBITS-1){1'b1}}};
   localparam logic [NBITS-1:0] MINP   = {{(NBITS-1){1'b0}}, 1'b1};
   localparam logic [NBITS-1:0] TOPBIT = {2'b01, {(NBITS-2){1'b0}}};

   logic signed [KW-1:0] kn;
   logic [ES-1:0]        en;
   logic [FW-1:0]        qn;
   logic [FW-2:0]        fr;
   logic [KW-1:0]        rl;
   logic [NBITS-1:0]     regime, expf, fracf, u, lowmask, rtmp;
   logic                 rnd, stk;

   always_comb begin
      kn = k;
      en = e;
      qn = q;
      if (!q[FW-1]) begin
         qn = q << 1;
         if (e == '0) begin
            en = '1;
            kn = k - K_ONE;
         end else begin
            en = e - 1'b1;
         end
      end
      fr      = qn[FW-2:0];
      rl      = kn[KW-1] ? -kn : (kn + K_ONE);
      regime  = kn[KW-1] ? (TOPBIT >> rl) : (MAXP - (MAXP >> rl));
      expf    = '0;
      fracf   = '0;
      lowmask = '0;
      rtmp    = '0;
      rnd     = 1'b0;
      stk     = rem_nz;
      u       = '0;
      if (rl > RL_MAX) begin
         u = kn[KW-1] ? MINP : MAXP;
      end else begin
         if (rl <= RL_FULL) begin
            fracf   = NBITS'(fr >> (rl + 2));
            rtmp    = NBITS'(fr >> (rl + 1));
            rnd     = rtmp[0];
            lowmask = (MINP << (rl + 1)) - 1'b1;
            stk     = stk | (|(NBITS'(fr) & lowmask));
            expf    = NBITS'(en) << (RL_FULL - rl);
         end else if (rl == RL_EDGE) begin
            rnd  = en[0];
            expf = NBITS'(en >> 1);
            stk  = stk | (fr != '0);
         end else begin
            rnd = en[1];
            stk = stk | en[0] | (fr != '0);
         end
         u = regime + expf + fracf;
         if (rnd) u = u + {{(NBITS-1){1'b0}}, (u[0] | stk)};
      end
      res = sgn ? (~u + 1'b1) : u;
   end
endmodule

// File: rtl/posit_divider.sv
`timescale 1ns/1ps
module posit_divider #(
   parameter int NBITS        = 32,
   parameter int ES           = 2,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NBITS-1:0] dividend,
   input  logic [NBITS-1:0] divisor,
   output logic             busy,
   output logic             done,
   output logic [NBITS-1:0] quotient
);
   import posit_div_pkg::*;

   localparam int FW   = NBITS - 1;
   localparam int KW   = $clog2(NBITS) + 3;
   localparam int CNTW = $clog2(FW + 1);
   localparam logic [NBITS-1:0] NAR_WORD = {1'b1, {(NBITS-1){1'b0}}};
   localparam logic signed [KW-1:0] K_ONE = KW'(1);

   generate
      if (NBITS != 32 || ES != 2) begin : g_cfg_bad
         $error("posit_divider supports only NBITS=32 with ES=2");
      end
   endgenerate

   pd_state_e   state;
   pd_special_e spec_r;
   logic [CNTW-1:0] cnt;
   logic            sgn_r;
   logic signed [KW-1:0] k_r, k_load;
   logic [ES-1:0]   e_r;
   logic signed [ES:0] ediff;

   logic sa, za, na, sb, zb, nb;
   logic signed [KW-1:0] ka, kb;
   logic [ES-1:0] ea, eb;
   logic [FW-1:0] fa, fb, fq;
   logic          rem_nz, accept;
   logic [NBITS-1:0] packed_res;

   posit_div_unpack #(.NBITS(NBITS), .ES(ES), .KW(KW), .FW(FW)) u_unpack_a (
      .word(dividend), .sgn(sa), .is_zero(za), .is_nar(na), .k(ka), .e(ea), .frac(fa));
   posit_div_unpack #(.NBITS(NBITS), .ES(ES), .KW(KW), .FW(FW)) u_unpack_b (
      .word(divisor), .sgn(sb), .is_zero(zb), .is_nar(nb), .k(kb), .e(eb), .frac(fb));

   assign accept = start && (state == PD_IDLE);
   assign busy   = (state != PD_IDLE);
   assign ediff  = $signed({1'b0, ea}) - $signed({1'b0, eb});
   assign k_load = (ka - kb) - (ediff[ES] ? K_ONE : '0);

   posit_div_frac #(.FW(FW), .NONRESTORING(NONRESTORING)) u_frac (
      .clk(clk), .rst_n(rst_n), .load(accept), .step(state == PD_RUN),
      .dvd(fa), .dvs(fb), .quot(fq), .rem_nz(rem_nz));

   posit_div_pack #(.NBITS(NBITS), .ES(ES), .KW(KW), .FW(FW)) u_pack (
      .sgn(sgn_r), .k(k_r), .e(e_r), .q(fq), .rem_nz(rem_nz), .res(packed_res));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= PD_IDLE;
         spec_r   <= SP_NONE;
         cnt      <= '0;
         sgn_r    <= 1'b0;
         k_r      <= '0;
         e_r      <= '0;
         done     <= 1'b0;
         quotient <= '0;
      end else begin
         done <= 1'b0;
         case (state)
            PD_IDLE: if (accept) begin
               state  <= PD_RUN;
               cnt    <= '0;
               sgn_r  <= sa ^ sb;
               k_r    <= k_load;
               e_r    <= ediff[ES-1:0];
               spec_r <= (na || nb || zb) ? SP_NAR : (za ? SP_ZERO : SP_NONE);
            end
            PD_RUN: begin
               cnt <= cnt + 1'b1;
               if (cnt == CNTW'(FW - 1)) state <= PD_FIN;
            end
            default: begin
               case (spec_r)
                  SP_NAR:  quotient <= NAR_WORD;
                  SP_ZERO: quotient <= '0;
                  default: quotient <= packed_res;
               endcase
               done  <= 1'b1;
               state <= PD_IDLE;
            end
         endcase
      end
   end
endmodule

module posit_divider_chk #(
   parameter int NBITS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [NBITS-1:0] dividend,
   input logic [NBITS-1:0] divisor,
   input logic             busy,
   input logic             done,
   input logic [NBITS-1:0] quotient
);
   localparam int LAT = NBITS;
   localparam int LW  = $clog2(NBITS) + 2;
   localparam logic [NBITS-1:0] NAR_WORD = {1'b1, {(NBITS-1){1'b0}}};

   logic [NBITS-1:0] a_cap, b_cap;
   logic [LW-1:0]    lat_cnt;
   logic             nar_c, zero_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_cap   <= '0;
         b_cap   <= '0;
         lat_cnt <= '0;
      end else if (start && !busy) begin
         a_cap   <= dividend;
         b_cap   <= divisor;
         lat_cnt <= '0;
      end else if (busy) begin
         lat_cnt <= lat_cnt + 1'b1;
      end
   end

   assign nar_c  = (b_cap == '0) || (a_cap == NAR_WORD) || (b_cap == NAR_WORD);
   assign zero_c = (a_cap == '0) && !nar_c;

   // R1
   nar_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && nar_c) |-> (quotient == NAR_WORD));
   // R2
   zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && zero_c) |-> (quotient == '0));
   // R3
   sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !nar_c && !zero_c) |-> (quotient[NBITS-1] == (a_cap[NBITS-1] ^ b_cap[NBITS-1])));
   // R9
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == LW'(LAT)));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R10
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(quotient));
endmodule

bind posit_divider posit_divider_chk #(.NBITS(NBITS)) u_posit_divider_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
   .busy(busy), .done(done), .quotient(quotient));

// File: tb/test_posit_divider.sv
`timescale 1ns/1ps
module test_posit_divider;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] dividend = '0;
   logic [31:0] divisor = '0;
   logic        busy, done;
   logic [31:0] quotient;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   int          cyc_q[$];

   posit_divider i_posit_divider (
      .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
      .busy(busy), .done(done), .quotient(quotient));

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   // driver: issue one division and queue its expected result
   task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [31:0] e,
                        input string tag, input bit poke);
      @(negedge clk);
      while (busy) @(negedge clk);
      dividend = a;
      divisor  = b;
      start    = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      cyc_q.push_back(cyc);
      @(negedge clk);
      start = 1'b0;
      check(busy && !done, "R9", "busy after accepted start", {30'b0, busy, done}, 32'h2);
      if (poke) begin
         // R10: extra start pulses during busy must be ignored
         dividend = ~a;
         divisor  = 32'h4000_0000;
         start    = 1'b1;
         repeat (3) @(negedge clk);
         start = 1'b0;
      end
   endtask

   // monitor: compare results as they come out
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10", "done without a pending request", quotient, 32'h0);
         end else begin
            logic [31:0] e;
            string       t;
            int          c0;
            e  = exp_q.pop_front();
            t  = tag_q.pop_front();
            c0 = cyc_q.pop_front();
            check(quotient == e, t, "quotient", quotient, e);
            check((cyc - c0) == 33, "R9", "done latency", cyc - c0, 33);
         end
      end
   end

   initial begin
      #80000;
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && quotient == 32'h0, "R9", "reset state",
            {quotient[29:0], busy, done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done, "R9", "idle after reset", {30'b0, busy, done}, 32'h0);

      // R1 NaR cases
      issue(32'h8000_0000, 32'h4000_0000, 32'h8000_0000, "R1", 1'b0);
      issue(32'h4000_0000, 32'h0000_0000, 32'h8000_0000, "R1", 1'b0);
      issue(32'h0000_0000, 32'h0000_0000, 32'h8000_0000, "R1", 1'b0);
      issue(32'h4000_0000, 32'h8000_0000, 32'h8000_0000, "R1", 1'b0);
      // R2 zero dividend
      issue(32'h0000_0000, 32'h4C00_0000, 32'h0000_0000, "R2", 1'b0);
      issue(32'h0000_0000, 32'hC000_0000, 32'h0000_0000, "R2", 1'b0);
      // R4 exact
      issue(32'h4C00_0000, 32'h4800_0000, 32'h4400_0000, "R4", 1'b0);
      issue(32'h4000_0000, 32'h4800_0000, 32'h3800_0000, "R4", 1'b0);
      issue(32'h5800_0000, 32'h5000_0000, 32'h4800_0000, "R4", 1'b0);
      issue(32'h6000_0000, 32'h3800_0000, 32'h6400_0000, "R4", 1'b0);
      // R5 normalisation with exponent wrap
      issue(32'h4000_0000, 32'h4400_0000, 32'h3AAA_AAAB, "R5", 1'b0);
      // R6 rounding, with a start poke during busy (R10)
      issue(32'h4000_0000, 32'h4C00_0000, 32'h32AA_AAAB, "R6", 1'b1);
      issue(32'h4000_0001, 32'h7000_0000, 32'h1000_0000, "R6", 1'b0);
      issue(32'h4000_0003, 32'h7000_0000, 32'h1000_0002, "R6", 1'b1);
      // R3 signs
      issue(32'hB400_0000, 32'h4800_0000, 32'hBC00_0000, "R3", 1'b0);
      issue(32'hC000_0000, 32'hB400_0000, 32'h32AA_AAAB, "R3", 1'b0);
      issue(32'h4000_0000, 32'hC000_0000, 32'hC000_0000, "R3", 1'b0);
      // R7 saturation
      issue(32'h7FFF_FFFF, 32'h0000_0001, 32'h7FFF_FFFF, "R7", 1'b0);
      issue(32'h0000_0001, 32'h7FFF_FFFF, 32'h0000_0001, "R7", 1'b0);
      issue(32'h8000_0001, 32'h0000_0001, 32'h8000_0001, "R7", 1'b0);
      // R8 long regimes
      issue(32'h7FFF_FFFF, 32'h6C00_0000, 32'h7FFF_FFFC, "R8", 1'b0);
      issue(32'h7FFF_FFFF, 32'h6400_0000, 32'h7FFF_FFFE, "R8", 1'b0);
      issue(32'h7FFF_FFFF, 32'h7000_0000, 32'h7FFF_FFFC, "R8", 1'b0);
      issue(32'h7FFF_FFFF, 32'h6000_0000, 32'h7FFF_FFFE, "R8", 1'b0);
      issue(32'h7FFF_FFFF, 32'h4800_0000, 32'h7FFF_FFFF, "R8", 1'b0);
      issue(32'h4000_0000, 32'h7FFF_FFFF, 32'h0000_0001, "R8", 1'b0);

      while (exp_q.size() != 0) @(negedge clk);
      @(negedge clk);
      begin
         logic [31:0] held;
         held = quotient;
         // R10: result held while idle
         repeat (6) @(negedge clk);
         check(quotient == held && !done, "R10", "result held after done", quotient, held);
      end
      summary();
      $finish;
   end
endmodule